// File: doc/BRIEF.md
# Processor Low-Power Entry and Wake Controller

This block decides when a processor core drops into a low-power state and when it comes back. The core raises a wait-for-event or wait-for-interrupt request, or signals that an interrupt handler has just returned to thread level. The block then asserts either a light-sleep or a deep-sleep output. When a qualifying wake source appears, it releases that output and issues a single-cycle wake pulse.

A three-bit control word sets the behaviour. Its fields are: an automatic sleep on handler return, a choice between light and deep sleep, and whether any newly pending interrupt counts as an event, even a masked one. Software reaches the control word only while the privilege flag is high.

A one-bit event latch records wake events that arrive while the core is running. The next wait-for-event request consumes the latch and does not sleep. Interrupt pending bits are treated as edges: a bit counts only in the cycle after it rises from 0 to 1.

Top module: `lp_wake_ctl`

## Requirements
- R1: After reset, the control word reads 0. The light-sleep, deep-sleep, wake, access-error and event-latch outputs are all 0.
- R2: Control word layout: bit 1 enables sleep on handler return, bit 2 selects deep sleep, and bit 4 enables wake on any pending interrupt. Only these three bits can be written. All other bits read 0. Read data appears on `reg_rdata` one cycle after `reg_rd`.
- R3: A write made while `priv` is 0 leaves the control word unchanged. A read made while `priv` is 0 returns 0 on `reg_rdata` and raises `acc_err` for exactly that one following cycle.
- R4: A low-power entry asserts exactly one sleep output one cycle after the request. The output is `slp_light` if control bit 2 was 0 at entry, and `slp_deep` if it was 1.
- R5: While asleep from a wait-for-event, the core wakes on any of three sources: a `sev` pulse, a 0-to-1 change of `ext_evt`, or a rising pending bit whose enable bit is 1. On wake, `wake` is high for one cycle, and both sleep outputs drop on that same edge.
- R6: A rising pending bit whose enable bit is 0 wakes a wait-for-event only when control bit 4 is 1.
- R7: A wake event seen while the core is running sets `evt_latch`. The next wait-for-event request clears the latch, does not sleep and does not pulse `wake`.
- R8: When a wake event and a wait-for-event request arrive in the same cycle, no sleep is entered and `evt_latch` ends up 0.
- R9: A wait-for-interrupt sleep ends only on a rising pending bit that is enabled. Send-event pulses, external events and masked pending bits neither wake it nor change `evt_latch`.
- R10: When control bit 1 is 1, a `handler_exit` strobe enters sleep in the mode chosen by bit 2, and an enabled rising pending bit ends that sleep. When bit 1 is 0, the strobe has no effect.
- R11: A pending bit held high wakes nothing after its first cycle. Only a fresh 0-to-1 change counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv | input | 1 | Privilege flag qualifying register access |
| reg_wr | input | 1 | Control word write strobe |
| reg_rd | input | 1 | Control word read strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Registered control word read data |
| acc_err | output | 1 | One-cycle flag for an unprivileged read |
| wfe_req | input | 1 | Wait-for-event request |
| wfi_req | input | 1 | Wait-for-interrupt request |
| sev | input | 1 | Send-event pulse |
| ext_evt | input | 1 | External event input (rising edge counts) |
| handler_exit | input | 1 | Strobe: return from handler to thread level |
| irq_pend | input | IRQ_W | Interrupt pending vector |
| irq_en | input | IRQ_W | Interrupt enable vector |
| slp_light | output | 1 | Light-sleep state active |
| slp_deep | output | 1 | Deep-sleep state active |
| wake | output | 1 | Single-cycle wake pulse |
| evt_latch | output | 1 | Recorded-event latch |

## Verification
Every result is due exactly one clock edge after its stimulus. This applies to sleep entry, the wake pulse, latch updates, read data and the access-error flag, because each output is a register fed from the inputs sampled at that edge. The bench changes inputs on the falling edge and reads outputs at the next falling edge, so each sample falls after exactly one rising edge. A sweep covers all eight control word settings. For each setting it tries every wake source against wait-for-event, wait-for-interrupt and handler-return sleep, and checks the wake pulse in that single due cycle and a quiet output in the cycle after.

// File: rtl/lpw_pkg.sv
package lpw_pkg;
  typedef enum logic [1:0] {
    ST_RUN      = 2'd0,
    ST_WAIT_EVT = 2'd1,
    ST_WAIT_IRQ = 2'd2
  } lpw_state_e;

  localparam int unsigned BIT_EXIT = 1;
  localparam int unsigned BIT_DEEP = 2;
  localparam int unsigned BIT_PEND = 4;
endpackage

// File: rtl/lpw_regs.sv
module lpw_regs #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          priv,
  input  logic          wr,
  input  logic          rd,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          acc_err,
  output logic          exit_en,
  output logic          deep_en,
  output logic          pend_en
);
  import lpw_pkg::*;

  logic unused_wdata;
  assign unused_wdata = ^wdata;

  logic [DW-1:0] word;
  always_comb begin
    word = '0;
    word[BIT_EXIT] = exit_en;
    word[BIT_DEEP] = deep_en;
    word[BIT_PEND] = pend_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      exit_en <= 1'b0;
      deep_en <= 1'b0;
      pend_en <= 1'b0;
      rdata   <= '0;
      acc_err <= 1'b0;
    end else begin
      if (wr && priv) begin
        exit_en <= wdata[BIT_EXIT];
        deep_en <= wdata[BIT_DEEP];
        pend_en <= wdata[BIT_PEND];
      end
      acc_err <= rd && !priv;
      if (rd) rdata <= priv ? word : '0;
    end
  end
endmodule

// File: rtl/lpw_wake_src.sv
module lpw_wake_src #(
  parameter int unsigned IRQ_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IRQ_W-1:0] pend,
  input  logic [IRQ_W-1:0] en,
  input  logic             sev,
  input  logic             ext_evt,
  input  logic             pend_all,
  output logic             evt,
  output logic             irq_wake
);
  logic [IRQ_W-1:0] pend_q;
  logic             ext_q;
  logic [IRQ_W-1:0] rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      ext_q  <= 1'b0;
    end else begin
      pend_q <= pend;
      ext_q  <= ext_evt;
    end
  end

  assign rise     = pend & ~pend_q;
  assign irq_wake = |(rise & en);
  assign evt      = sev | (ext_evt & ~ext_q) | irq_wake | (pend_all & |rise);
endmodule

// File: rtl/lpw_fsm.sv
module lpw_fsm (
  input  logic clk,
  input  logic rst,
  input  logic wfe,
  input  logic wfi,
  input  logic hexit,
  input  logic exit_en,
  input  logic deep_en,
  input  logic evt,
  input  logic irq_wake,
  output logic slp_light,
  output logic slp_deep,
  output logic wake,
  output logic latch
);
  import lpw_pkg::*;

  lpw_state_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_RUN;
      slp_light <= 1'b0;
      slp_deep  <= 1'b0;
      wake      <= 1'b0;
      latch     <= 1'b0;
    end else begin
      wake <= 1'b0;
      case (st)
        ST_RUN: begin
          if (wfe) begin
            if (latch || evt) begin
              latch <= 1'b0;
            end else begin
              st        <= ST_WAIT_EVT;
              slp_light <= !deep_en;
              slp_deep  <= deep_en;
            end
          end else begin
            latch <= latch | evt;
            if ((wfi || (hexit && exit_en)) && !irq_wake) begin
              st        <= ST_WAIT_IRQ;
              slp_light <= !deep_en;
              slp_deep  <= deep_en;
            end
          end
        end
        ST_WAIT_EVT: begin
          if (evt) begin
            st        <= ST_RUN;
            wake      <= 1'b1;
            slp_light <= 1'b0;
            slp_deep  <= 1'b0;
          end
        end
        ST_WAIT_IRQ: begin
          if (irq_wake) begin
            st        <= ST_RUN;
            wake      <= 1'b1;
            slp_light <= 1'b0;
            slp_deep  <= 1'b0;
          end
        end
        default: begin
          st        <= ST_RUN;
          slp_light <= 1'b0;
          slp_deep  <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/lp_wake_ctl.sv
module lp_wake_ctl #(
  parameter int unsigned DW    = 32,
  parameter int unsigned IRQ_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             priv,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             acc_err,
  input  logic             wfe_req,
  input  logic             wfi_req,
  input  logic             sev,
  input  logic             ext_evt,
  input  logic             handler_exit,
  input  logic [IRQ_W-1:0] irq_pend,
  input  logic [IRQ_W-1:0] irq_en,
  output logic             slp_light,
  output logic             slp_deep,
  output logic             wake,
  output logic             evt_latch
);
  logic exit_en, deep_en, pend_en;
  logic evt, irq_wake;

  lpw_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .priv(priv), .wr(reg_wr), .rd(reg_rd),
    .wdata(reg_wdata), .rdata(reg_rdata), .acc_err(acc_err),
    .exit_en(exit_en), .deep_en(deep_en), .pend_en(pend_en)
  );

  lpw_wake_src #(.IRQ_W(IRQ_W)) u_src (
    .clk(clk), .rst(rst), .pend(irq_pend), .en(irq_en),
    .sev(sev), .ext_evt(ext_evt), .pend_all(pend_en),
    .evt(evt), .irq_wake(irq_wake)
  );

  lpw_fsm u_fsm (
    .clk(clk), .rst(rst), .wfe(wfe_req), .wfi(wfi_req),
    .hexit(handler_exit), .exit_en(exit_en), .deep_en(deep_en),
    .evt(evt), .irq_wake(irq_wake),
    .slp_light(slp_light), .slp_deep(slp_deep),
    .wake(wake), .latch(evt_latch)
  );
endmodule

// File: rtl/lp_wake_ctl_chk.sv
module lp_wake_ctl_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          priv,
  input logic          reg_rd,
  input logic [DW-1:0] reg_rdata,
  input logic          acc_err,
  input logic          wfe_req,
  input logic          slp_light,
  input logic          slp_deep,
  input logic          wake,
  input logic          evt_latch
);
  localparam logic [DW-1:0] WMASK = DW'(32'h16);

  p_one_mode_r4: assert property (@(posedge clk) disable iff (rst)
    !(slp_light && slp_deep));

  p_wake_drops_sleep_r5: assert property (@(posedge clk) disable iff (rst)
    wake |-> (!slp_light && !slp_deep));

  p_wake_from_sleep_r5: assert property (@(posedge clk) disable iff (rst)
    wake |-> $past(slp_light || slp_deep));

  p_wake_single_r5: assert property (@(posedge clk) disable iff (rst)
    wake |=> !wake);

  p_unpriv_read_r3: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !priv) |=> (reg_rdata == '0 && acc_err));

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata & ~WMASK) == '0);

  p_latch_consumed_r7: assert property (@(posedge clk) disable iff (rst)
    (wfe_req && evt_latch && !slp_light && !slp_deep)
      |=> (!evt_latch && !slp_light && !slp_deep));
endmodule

bind lp_wake_ctl lp_wake_ctl_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .priv(priv), .reg_rd(reg_rd),
  .reg_rdata(reg_rdata), .acc_err(acc_err), .wfe_req(wfe_req),
  .slp_light(slp_light), .slp_deep(slp_deep), .wake(wake),
  .evt_latch(evt_latch)
);

// File: tb/lp_wake_ctl_tb.sv
`timescale 1ns/1ps
module lp_wake_ctl_tb;
  logic clk = 0, rst = 1;
  logic priv = 1, reg_wr = 0, reg_rd = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic acc_err, wfe_req = 0, wfi_req = 0, sev = 0, ext_evt = 0, handler_exit = 0;
  logic [3:0] irq_pend = 0, irq_en = 4'b0001;
  logic slp_light, slp_deep, wake, evt_latch;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lp_wake_ctl #(.DW(32), .IRQ_W(4)) u_dut (
    .clk(clk), .rst(rst), .priv(priv), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_err(acc_err),
    .wfe_req(wfe_req), .wfi_req(wfi_req), .sev(sev), .ext_evt(ext_evt),
    .handler_exit(handler_exit), .irq_pend(irq_pend), .irq_en(irq_en),
    .slp_light(slp_light), .slp_deep(slp_deep), .wake(wake), .evt_latch(evt_latch)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wreg(logic [31:0] v, logic p);
    reg_wr = 1; reg_wdata = v; priv = p; cyc(); reg_wr = 0; priv = 1;
  endtask

  task automatic rreg(logic p);
    reg_rd = 1; priv = p; cyc(); reg_rd = 0; priv = 1;
  endtask

  // 0 sev, 1 external rise, 2 enabled pending rise, 3 masked pending rise
  task automatic fire(int s);
    case (s)
      0: sev = 1;
      1: ext_evt = 1;
      2: irq_pend[0] = 1;
      default: irq_pend[1] = 1;
    endcase
    cyc();
    sev = 0; ext_evt = 0; irq_pend = 0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) cyc();
    rst = 0;
    cyc();
    // R1 reset state
    chk("R1 sleep", {slp_light, slp_deep, wake, acc_err, evt_latch}, 0);
    rreg(1);
    chk("R1 ctrl", reg_rdata, 0);

    // R2 writable fields only
    wreg(32'hFFFF_FFFF, 1); rreg(1);
    chk("R2 mask", reg_rdata, 32'h16);

    // R3 unprivileged access
    wreg(32'h0, 0); rreg(1);
    chk("R3 wr ignored", reg_rdata, 32'h16);
    rreg(0);
    chk("R3 rd zero", reg_rdata, 0);
    chk("R3 err", acc_err, 1);
    cyc();
    chk("R3 err pulse", acc_err, 0);

    for (int cfg = 0; cfg < 8; cfg++) begin
      automatic logic ex = cfg[0], dp = cfg[1], pe = cfg[2];
      wreg({27'd0, pe, 1'b0, dp, ex, 1'b0}, 1); rreg(1);
      chk("R2 readback", reg_rdata, {27'd0, pe, 1'b0, dp, ex, 1'b0});
      for (int s = 0; s < 4; s++) begin
        automatic logic exp_w = (s != 3) || pe;
        // wait-for-event
        wfe_req = 1; cyc(); wfe_req = 0;
        chk("R4 wfe mode", {slp_light, slp_deep}, {~dp, dp});
        fire(s);
        chk(pe ? "R6 wfe wake" : "R5 wfe wake", wake, exp_w);
        chk("R5 sleep drop", {slp_light, slp_deep}, exp_w ? 2'b00 : {~dp, dp});
        if (!exp_w) begin fire(0); chk("R5 sev wake", wake, 1); end
        cyc();
        chk("R5 pulse end", {wake, evt_latch}, 0);
        // wait-for-interrupt
        wfi_req = 1; cyc(); wfi_req = 0;
        chk("R4 wfi mode", {slp_light, slp_deep}, {~dp, dp});
        fire(s);
        chk("R9 wfi wake", wake, s == 2);
        if (s != 2) begin
          chk("R9 latch held", evt_latch, 0);
          fire(2); chk("R9 irq wake", wake, 1);
        end
        cyc();
        // handler return
        handler_exit = 1; cyc(); handler_exit = 0;
        chk("R10 exit sleep", {slp_light, slp_deep}, ex ? {~dp, dp} : 2'b00);
        if (ex) begin
          fire(0); chk("R10 sev no wake", wake, 0);
          fire(2); chk("R10 irq wake", wake, 1);
        end
        cyc();
      end
    end

    // R7 latch set while running, consumed by next wait-for-event
    wreg(32'h0, 1);
    fire(0);
    chk("R7 latch set", evt_latch, 1);
    wfe_req = 1; cyc(); wfe_req = 0;
    chk("R7 consumed", {slp_light, slp_deep, wake, evt_latch}, 0);
    fire(3);
    chk("R6 masked no latch", evt_latch, 0);

    // R8 event and request in the same cycle
    wfe_req = 1; sev = 1; cyc(); wfe_req = 0; sev = 0;
    chk("R8 no sleep", {slp_light, slp_deep, evt_latch}, 0);

    // R11 level-held pending bit
    irq_pend[0] = 1; cyc();
    chk("R11 first edge latched", evt_latch, 1);
    wfe_req = 1; cyc();
    chk("R11 consumed", {slp_light, evt_latch}, 0);
    cyc(); wfe_req = 0;
    chk("R11 level sleeps", slp_light, 1);
    cyc();
    chk("R11 held no wake", {wake, slp_light}, 2'b01);
    irq_pend[0] = 0; cyc();
    irq_pend[0] = 1; cyc();
    chk("R11 new edge wakes", wake, 1);
    irq_pend = 0; cyc();

    done = 1;
    finish_run();
  end
endmodule